// File: doc/BRIEF.md
# M23 DS3 Frame Overhead Inserter

This block sits on the transmit side of an M23-format DS3 path. It takes a serial payload stream together with a bit position counter aligned to the 4760-bit multiframe. In the output stream it replaces every overhead bit with a generated value. The multiframe has seven 680-bit subframes. Each subframe is eight 85-bit blocks, and each block opens with one overhead bit followed by 84 payload bits.

The overhead written is as follows:
- the fixed multiframe alignment pattern;
- the fixed subframe alignment pattern;
- the defect indication bits, from a selectable source;
- the line parity bits, computed over the payload of the previous multiframe;
- one application identification bit;
- triplicated per-tributary stuff control bits.

The seven stuff requests are captured once per multiframe. The output is registered once and carries a frame-start flag.

Top module: `m23_oh_insert`

Within a subframe, the overhead bit at the start of block b sits at offset 85*b.

| Block | Overhead bit | Where and what |
|-------|--------------|----------------|
| 0 | X | subframes 1 and 2 |
| 0 | P | subframes 3 and 4 |
| 0 | M | subframes 5, 6 and 7 |
| 1, 3, 5, 7 | F | every subframe |
| 2, 4, 6 | C | every subframe |

## Requirements
- R1: Every bit whose offset within its 85-bit block is not 0 is payload, and it appears unchanged on `data_o` one clock after it is presented.
- R2: `data_o` and `sof_o` reflect the inputs of the previous clock. `sof_o` is 1 exactly when `pos_i` was 0 in that clock.
- R3: The M-bits at positions 2720, 3400 and 4080 are driven to 0, 1 and 0.
- R4: In every subframe, the F-bits at block offsets 85, 255, 425 and 595 are driven to 1, 0, 0 and 1.
- R5: The X-bits at positions 0 and 680 carry the defect indication selected by `rdi_mode_i`. The encodings are: 2'b01 forces 1, 2'b10 forces 0, and 2'b00 and 2'b11 select automatic.
- R6: In automatic mode, an X-bit is 0 if any bit of `rx_defect_i` is 1 in that clock, and 1 otherwise.
- R7: In subframe k (1..7), the C-bits at block offsets 170, 340 and 510 all carry `stuff_req_i[k-1]`. The one exception is stated in R8.
- R8: The first C-bit of subframe 1 (position 170) carries `aic_i`.
- R9: `stuff_req_i` is sampled when `pos_i` is 0. Changes at any other time have no effect until the next multiframe.
- R10: The P-bits at positions 1360 and 2040 both carry the XOR of the 4704 payload input bits of the previous complete multiframe. Until a complete multiframe has been seen since reset, they are 0.
- R11: While `rst_ni` is low, `data_o` and `sof_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | Serial payload in |
| pos_i | input | 13 | Bit position within the multiframe, 0..4759 |
| rdi_mode_i | input | 2 | Defect indication source select |
| rx_defect_i | input | 3 | Receive defect flags, used in automatic mode |
| aic_i | input | 1 | Application identification bit value |
| stuff_req_i | input | 7 | Stuff request per tributary, bit k-1 for subframe k |
| data_o | output | 1 | Serial DS3 stream with overhead inserted |
| sof_o | output | 1 | Multiframe start, high with output bit 0 |

## Verification
The payload is random data. A positional error therefore shows up either as a payload mismatch or as a parity mismatch one multiframe later.

The run starts partway through a multiframe. This shows whether the parity bits stay at 0 across the first complete multiframe and only then take the XOR of that frame.

The multiframes cycle through all four source-select codes. The defect flags alternate between the two X positions, which separates forced values from automatic ones and X1 from X2.

The stuff requests change in the middle of multiframes. This distinguishes a value sampled at the frame start from a value taken live.

// File: rtl/m23_oh_pkg.sv
package m23_oh_pkg;
  typedef enum logic [2:0] {
    OH_PAY,
    OH_X,
    OH_P,
    OH_M,
    OH_F,
    OH_C
  } oh_kind_e;
endpackage

// File: rtl/m23_pos_decode.sv
module m23_pos_decode
  import m23_oh_pkg::*;
#(
  parameter int NUM_SF  = 7,
  parameter int NUM_BLK = 8,
  parameter int BLK_LEN = 85,
  parameter int CNT_W   = 13,
  parameter int SF_W    = 3
) (
  input  logic [CNT_W-1:0] pos_i,
  output oh_kind_e         kind_o,
  output logic [SF_W-1:0]  sf_o,
  output logic [1:0]       c_idx_o,
  output logic             fix_val_o
);
  localparam int SF_LEN = NUM_BLK * BLK_LEN;
  localparam int MF_LEN = NUM_SF * SF_LEN;

  int unsigned p, sf, off, blk;
  logic head;

  always_comb begin
    p    = int'(pos_i);
    sf   = p / SF_LEN;
    off  = p - sf * SF_LEN;
    blk  = off / BLK_LEN;
    head = (off % BLK_LEN) == 0 && p < MF_LEN;

    kind_o    = OH_PAY;
    fix_val_o = 1'b0;
    c_idx_o   = 2'd0;
    sf_o      = SF_W'(sf);

    if (head) begin
      if (blk == 0) begin
        if (sf < 2) begin
          kind_o = OH_X;
        end else if (sf < 4) begin
          kind_o = OH_P;
        end else begin
          kind_o    = OH_M;
          fix_val_o = (sf == 5);
        end
      end else if (blk[0]) begin
        kind_o    = OH_F;
        // outer F-bits are 1, inner ones 0
        fix_val_o = (blk == 1) || (blk == NUM_BLK - 1);
      end else begin
        kind_o  = OH_C;
        c_idx_o = 2'(blk / 2 - 1);
      end
    end
  end
endmodule

// File: rtl/m23_parity.sv
module m23_parity #(
  parameter int CNT_W  = 13,
  parameter int MF_LEN = 4760
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] pos_i,
  input  logic             data_i,
  input  logic             pay_i,
  output logic             par_o
);
  logic acc_q, started_q, par_q;
  logic first, last, acc_n;

  assign first = pos_i == '0;
  assign last  = pos_i == CNT_W'(MF_LEN - 1);
  assign acc_n = acc_q ^ (pay_i & data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= 1'b0;
      started_q <= 1'b0;
      par_q     <= 1'b0;
    end else begin
      if (first) begin
        acc_q     <= 1'b0;
        started_q <= 1'b1;
      end else begin
        acc_q <= acc_n;
      end
      // only a multiframe seen from its start counts
      if (last && started_q) par_q <= acc_n;
    end
  end

  assign par_o = par_q;

  // R10
  par_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started_q |-> par_q == 1'b0);
endmodule

// File: rtl/m23_stuff_hold.sv
module m23_stuff_hold #(
  parameter int NUM_SF = 7,
  parameter int CNT_W  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  pos_i,
  input  logic [NUM_SF-1:0] req_i,
  output logic [NUM_SF-1:0] hold_o
);
  logic [NUM_SF-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else if (pos_i == '0) hold_q <= req_i;
  end

  assign hold_o = hold_q;

  // R9
  stuff_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_i != '0 |=> $stable(hold_q));
endmodule

// File: rtl/m23_oh_insert.sv
module m23_oh_insert
  import m23_oh_pkg::*;
#(
  parameter int NUM_SF  = 7,
  parameter int NUM_BLK = 8,
  parameter int BLK_LEN = 85,
  parameter int NUM_DEF = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               data_i,
  input  logic [12:0]        pos_i,
  input  logic [1:0]         rdi_mode_i,
  input  logic [NUM_DEF-1:0] rx_defect_i,
  input  logic               aic_i,
  input  logic [NUM_SF-1:0]  stuff_req_i,
  output logic               data_o,
  output logic               sof_o
);
  localparam int SF_LEN = NUM_BLK * BLK_LEN;
  localparam int MF_LEN = NUM_SF * SF_LEN;
  localparam int CNT_W  = 13;
  localparam int SF_W   = $clog2(NUM_SF);

  oh_kind_e          kind;
  logic [SF_W-1:0]   sf;
  logic [1:0]        c_idx;
  logic              fix_val, par, rdi, data_n, live_q;
  logic [NUM_SF-1:0] stuff;

  m23_pos_decode #(
    .NUM_SF(NUM_SF), .NUM_BLK(NUM_BLK), .BLK_LEN(BLK_LEN),
    .CNT_W(CNT_W), .SF_W(SF_W)
  ) i_dec (
    .pos_i(pos_i), .kind_o(kind), .sf_o(sf), .c_idx_o(c_idx), .fix_val_o(fix_val)
  );

  m23_parity #(.CNT_W(CNT_W), .MF_LEN(MF_LEN)) i_par (
    .clk_i(clk_i), .rst_ni(rst_ni), .pos_i(pos_i), .data_i(data_i),
    .pay_i(kind == OH_PAY), .par_o(par)
  );

  m23_stuff_hold #(.NUM_SF(NUM_SF), .CNT_W(CNT_W)) i_stuff (
    .clk_i(clk_i), .rst_ni(rst_ni), .pos_i(pos_i), .req_i(stuff_req_i), .hold_o(stuff)
  );

  always_comb begin
    unique case (rdi_mode_i)
      2'b01:   rdi = 1'b1;
      2'b10:   rdi = 1'b0;
      default: rdi = ~|rx_defect_i;
    endcase
  end

  always_comb begin
    unique case (kind)
      OH_X:        data_n = rdi;
      OH_P:        data_n = par;
      OH_M, OH_F:  data_n = fix_val;
      OH_C:        data_n = (sf == '0 && c_idx == 2'd0) ? aic_i : stuff[sf];
      default:     data_n = data_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= 1'b0;
      sof_o  <= 1'b0;
      live_q <= 1'b0;
    end else begin
      data_o <= data_n;
      sof_o  <= pos_i == '0;
      live_q <= 1'b1;
    end
  end

  // R1
  pay_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(kind == OH_PAY) |-> data_o == $past(data_i));
  // R2
  sof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> sof_o == ($past(pos_i) == '0));
  // R3 R4
  fixed_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(kind == OH_M || kind == OH_F) |-> data_o == $past(fix_val));
  // R5
  x_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(kind == OH_X && rdi_mode_i == 2'b10) |-> !data_o);
endmodule

// File: tb/test_m23_oh_insert.sv
module test_m23_oh_insert;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       data_i = 1'b0;
  logic [12:0] pos_i = '0;
  logic [1:0] rdi_mode_i = 2'b00;
  logic [2:0] rx_defect_i = '0;
  logic       aic_i = 1'b0;
  logic [6:0] stuff_req_i = '0;
  logic       data_o, sof_o;

  m23_oh_insert i_m23_oh_insert (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .pos_i(pos_i),
    .rdi_mode_i(rdi_mode_i), .rx_defect_i(rx_defect_i), .aic_i(aic_i),
    .stuff_req_i(stuff_req_i), .data_o(data_o), .sof_o(sof_o)
  );

  always #2 clk_i = ~clk_i;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // model state
  bit       acc, par, started, have_exp;
  bit [6:0] stuff_h;
  bit       exp_d, exp_sof;
  string    exp_req;

  task automatic chk(string req, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at pos %0d", req, act, exp, pos_i);
    end
  endtask

  // compute expected output for the inputs just driven
  task automatic model(int p, bit d);
    int sf, off, blk, ci;
    sf  = p / 680;
    off = p % 680;
    blk = off / 85;
    if (p == 0) begin
      stuff_h = stuff_req_i;
      acc = 0;
      started = 1;
    end
    exp_sof = (p == 0);
    if (off % 85 != 0) begin
      exp_d = d; exp_req = "R1"; acc ^= d;
    end else if (blk == 0) begin
      if (sf < 2) begin
        if (rdi_mode_i == 2'b01) begin exp_d = 1; exp_req = "R5"; end
        else if (rdi_mode_i == 2'b10) begin exp_d = 0; exp_req = "R5"; end
        else begin exp_d = (rx_defect_i == 0); exp_req = "R6"; end
      end else if (sf < 4) begin
        exp_d = par; exp_req = "R10";
      end else begin
        exp_d = (sf == 5); exp_req = "R3";
      end
    end else if (blk % 2 == 1) begin
      exp_d = (blk == 1 || blk == 7); exp_req = "R4";
    end else begin
      ci = blk / 2 - 1;
      if (sf == 0 && ci == 0) begin exp_d = aic_i; exp_req = "R8"; end
      else begin
        exp_d = stuff_h[sf];
        exp_req = (stuff_req_i != stuff_h) ? "R9" : "R7";
      end
    end
    if (p == 4759 && started) par = acc;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int p;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      chk("R11", data_o, 1'b0);
      chk("R11", sof_o, 1'b0);
    end
    rst_ni = 1'b1;
    p = 4000;
    for (int c = 0; c < 760 + 5 * 4760; c++) begin
      int mf;
      bit d;
      mf = (c + 4000) / 4760;
      if (have_exp) begin
        chk(exp_req, data_o, exp_d);
        chk("R2", sof_o, exp_sof);
      end
      d = 1'($urandom);
      data_i      = d;
      pos_i       = 13'(p);
      rdi_mode_i  = 2'(mf % 4);
      rx_defect_i = (((p / 680) + mf) % 2 == 1) ? 3'b100 >> (mf % 3) : 3'b000;
      aic_i       = 1'(mf % 2);
      if (p % 1000 == 333) stuff_req_i = 7'($urandom);
      model(p, d);
      have_exp = 1;
      p = (p + 1) % 4760;
      @(negedge clk_i);
    end
    chk(exp_req, data_o, exp_d);
    chk("R2", sof_o, exp_sof);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule